// File: doc/BRIEF.md
# High-Voltage Flash Device Model

This block is a synthesizable, clocked behavioural model of a small byte-wide flash memory that is reprogrammed by a programmer-style algorithm. Its operating mode does not come from a command bus. It comes from two digital flags that stand in for high voltage on two pins that normally carry ordinary signals. One flag is on the programming-voltage pin and one is on the highest-order address line. The flags work together with an active-low chip enable and an active-low output enable. A testbench for a programmer controller instantiates the model in place of the real part. It then checks that the controller's pulses, erase sequences and identification reads have the right effect.

Programming can only clear bits. A programming pulse stores the AND of the old byte and the presented byte. Only a whole-array erase returns bits to one. Each programming or erase pulse is measured in clock cycles against a minimum width. Thresholds are parameters, so simulation can use scaled-down times. A pulse that ends too early leaves the array as it was and sets an error flag that stays set until reset. When the address high-voltage flag is on alone, the model answers with a two-byte identification pair, selected by address bit 0.

The data bus is split into an input half, an output half and an output-enable qualifier. The output half is forced to zero whenever the model is not driving.

Top module: `hv_flash_model`

## Requirements
- R1: After reset every byte of the array reads FFh, `err` is 0 and `dq_oe` is 0.
- R2: With both flags low, `dq_oe` is 1 and `dq_out` equals the stored byte at `addr` in the same cycle exactly when `ce_n` and `oe_n` are both 0. In every other case where neither identification nor read applies, `dq_oe` is 0 and `dq_out` is 0. `dq_oe` is never 1 while `vpp_hv` is 1.
- R3: Programming mode is `vpp_hv`=1 with `a9_hv`=0. A pulse starts at the first clock edge that samples `ce_n` low after an edge that sampled it high. The byte address and data used for the write are the ones sampled at that starting edge. Without a pulse under `vpp_hv`, the array never changes.
- R4: A programming pulse with at least `PROG_CYC` edges sampling `ce_n` low (default 20) updates the latched byte to old AND data. The update is visible from the edge that ends the pulse.
- R5: Erase mode is `vpp_hv`=1 with `a9_hv`=1. An erase pulse with at least `ERASE_CYC` low edges (default 100) sets every byte to FFh.
- R6: A programming or erase pulse shorter than its minimum leaves every byte unchanged and sets `err`. `err` then stays 1 until reset.
- R7: With `a9_hv`=1, `vpp_hv`=0 and `oe_n`=0, the model drives `MFR_ID` (default BFh) when `addr[0]`=0 and `DEV_ID` (default A4h) when `addr[0]`=1. This holds whatever the values of `ce_n` and the other address bits.
- R8: A pulse ends at the first edge that samples `ce_n` high, or at the first edge where its own mode no longer holds. Either way it is judged only by its low-edge count.
- R9: If `ce_n` was already low when the programming or erase mode was entered, no pulse starts. Raising and lowering the flags under a held-low `ce_n` changes nothing and leaves `err` as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; pulse widths are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data presented by the controller for programming |
| dq_out | output | DATA_W | Data driven by the model, zero when released |
| dq_oe | output | 1 | High while the model drives the bus |
| ce_n | input | 1 | Active-low chip enable, also the write/erase pulse |
| oe_n | input | 1 | Active-low output enable |
| vpp_hv | input | 1 | Programming voltage present on the enable/VPP pin |
| a9_hv | input | 1 | High voltage present on address line 9 |
| err | output | 1 | Sticky flag for a pulse shorter than its minimum |

## Verification
The case that needs care is a pulse that ends in the same clock edge as the next mode begins. One example is an erase finishing while the programming voltage drops and output enable falls, so that identification data appears on the bus in that same cycle. Another is a programming pulse ended by losing its voltage flag rather than by chip enable rising. The bench provokes both. It changes all the affected inputs on a single falling clock edge and samples the bus before the next rising edge. It then reads the array back to judge whether the ended pulse committed. A width-dependent assertion also requires read data to stay stable unless the programming voltage was present in the two cycles before.

// File: rtl/hvf_pkg.sv
package hvf_pkg;

    typedef enum logic [2:0] {
        M_NONE  = 3'd0,
        M_READ  = 3'd1,
        M_PROG  = 3'd2,
        M_ERASE = 3'd3,
        M_IDENT = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        PK_IDLE  = 2'd0,
        PK_PROG  = 2'd1,
        PK_ERASE = 2'd2
    } pulse_e;

endpackage

// File: rtl/hvf_mode_dec.sv
module hvf_mode_dec
    import hvf_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hv,
    input  logic  a9_hv,
    output mode_e mode
);

    // High-voltage flags take priority over the plain enables.
    always_comb begin
        if (vpp_hv && a9_hv) begin
            mode = M_ERASE;
        end else if (vpp_hv) begin
            mode = M_PROG;
        end else if (a9_hv) begin
            mode = oe_n ? M_NONE : M_IDENT;
        end else if (!ce_n && !oe_n) begin
            mode = M_READ;
        end else begin
            mode = M_NONE;
        end
    end

endmodule

// File: rtl/hvf_pulse_timer.sv
module hvf_pulse_timer
    import hvf_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              prog_go,
    output logic              erase_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              err
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] PROG_LIM  = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0] ERASE_LIM = CNT_W'(ERASE_CYC);

    typedef struct packed {
        pulse_e            kind;
        logic [CNT_W-1:0]  cnt;
        logic              ce_prev;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic held;
    logic wide_enough;

    always_comb begin
        tmr_d         = tmr_q;
        tmr_d.ce_prev = ce_n;
        prog_go       = 1'b0;
        erase_go      = 1'b0;
        held          = 1'b0;
        wide_enough   = 1'b0;

        case (tmr_q.kind)
            PK_IDLE: begin
                // Only a falling chip enable inside a write mode starts a pulse.
                if (!ce_n && tmr_q.ce_prev) begin
                    if (mode == M_PROG) begin
                        tmr_d.kind = PK_PROG;
                        tmr_d.cnt  = CNT_W'(1);
                        tmr_d.addr = addr;
                        tmr_d.data = din;
                    end else if (mode == M_ERASE) begin
                        tmr_d.kind = PK_ERASE;
                        tmr_d.cnt  = CNT_W'(1);
                    end
                end
            end
            default: begin
                held = !ce_n &&
                       (((tmr_q.kind == PK_PROG)  && (mode == M_PROG)) ||
                        ((tmr_q.kind == PK_ERASE) && (mode == M_ERASE)));
                wide_enough = (tmr_q.kind == PK_PROG) ? (tmr_q.cnt >= PROG_LIM)
                                                      : (tmr_q.cnt >= ERASE_LIM);
                if (held) begin
                    if (tmr_q.cnt != {CNT_W{1'b1}}) begin
                        tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
                    end
                end else begin
                    if (!wide_enough) begin
                        tmr_d.err = 1'b1;
                    end else if (tmr_q.kind == PK_PROG) begin
                        prog_go = 1'b1;
                    end else begin
                        erase_go = 1'b1;
                    end
                    tmr_d.kind = PK_IDLE;
                    tmr_d.cnt  = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q         <= '0;
            tmr_q.kind    <= PK_IDLE;
            tmr_q.ce_prev <= 1'b1;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign wr_addr = tmr_q.addr;
    assign wr_data = tmr_q.data;
    assign err     = tmr_q.err;

endmodule

// File: rtl/hvf_cell_array.sv
module hvf_cell_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_d [DEPTH];
    logic [DATA_W-1:0] cell_q [DEPTH];

    // Per-byte next value: erase sets all ones, programming only clears bits.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_comb begin
            cell_d[g] = cell_q[g];
            if (erase_go) begin
                cell_d[g] = {DATA_W{1'b1}};
            end else if (prog_go && (wr_addr == ADDR_W'(g))) begin
                cell_d[g] = cell_q[g] & wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= {DATA_W{1'b1}};
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= cell_d[i];
            end
        end
    end

    assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/hv_flash_model.sv
module hv_flash_model
    import hvf_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          DATA_W    = 8,
    parameter int          PROG_CYC  = 20,
    parameter int          ERASE_CYC = 100,
    parameter logic [7:0]  MFR_ID    = 8'hBF,
    parameter logic [7:0]  DEV_ID    = 8'hA4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hv,
    input  logic              a9_hv,
    output logic              err
);

    mode_e             mode;
    logic              prog_go;
    logic              erase_go;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    hvf_mode_dec i_mode_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hv (vpp_hv),
        .a9_hv  (a9_hv),
        .mode   (mode)
    );

    hvf_pulse_timer #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) i_pulse_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .mode     (mode),
        .addr     (addr),
        .din      (dq_in),
        .prog_go  (prog_go),
        .erase_go (erase_go),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .err      (err)
    );

    hvf_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_cell_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_go  (prog_go),
        .erase_go (erase_go),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (addr),
        .rd_data  (rd_data)
    );

    // Bus steering: array data in read mode, identifier pair in ident mode.
    always_comb begin
        dq_oe  = 1'b0;
        dq_out = '0;
        case (mode)
            M_READ: begin
                dq_oe  = 1'b1;
                dq_out = rd_data;
            end
            M_IDENT: begin
                dq_oe  = 1'b1;
                dq_out = addr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);
            end
            default: begin
                dq_oe  = 1'b0;
                dq_out = '0;
            end
        endcase
    end

endmodule

// File: rtl/hv_flash_model_chk.sv
module hv_flash_model_chk #(
    parameter int         ADDR_W = 6,
    parameter int         DATA_W = 8,
    parameter logic [7:0] MFR_ID = 8'hBF,
    parameter logic [7:0] DEV_ID = 8'hA4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hv,
    input logic              a9_hv,
    input logic              err
);

    logic rd_mode;
    assign rd_mode = !ce_n && !oe_n && !vpp_hv && !a9_hv;

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode |-> dq_oe); // R2

    AST_VPP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_hv |-> (!dq_oe && dq_out == '0)); // R2

    AST_ID_MFR: assert property (@(posedge clk) disable iff (!rst_n)
        (a9_hv && !vpp_hv && !oe_n && !addr[0]) |-> (dq_oe && dq_out == DATA_W'(MFR_ID))); // R7

    AST_ID_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        (a9_hv && !vpp_hv && !oe_n && addr[0]) |-> (dq_oe && dq_out == DATA_W'(DEV_ID))); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R6

    AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode && $past(rd_mode) && $stable(addr) && !$past(vpp_hv) && !$past(vpp_hv, 2))
        |-> $stable(dq_out)); // R3

endmodule

bind hv_flash_model hv_flash_model_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .dq_out (dq_out),
    .dq_oe  (dq_oe),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hv (vpp_hv),
    .a9_hv  (a9_hv),
    .err    (err)
);

// File: tb/test_hv_flash_model.sv
module test_hv_flash_model;

    localparam int CLK_PERIOD = 10;
    localparam int PROG_CYC   = 20;
    localparam int ERASE_CYC  = 100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] addr;
    logic [7:0] dq_in;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic       ce_n;
    logic       oe_n;
    logic       vpp_hv;
    logic       a9_hv;
    logic       err;

    int         n_checks = 0;
    int         n_fails  = 0;
    logic [7:0] exp_mem [64];
    logic       exp_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hv_flash_model i_hv_flash_model (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hv (vpp_hv),
        .a9_hv  (a9_hv),
        .err    (err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ce_n = 1'b1; oe_n = 1'b1; vpp_hv = 1'b0; a9_hv = 1'b0;
        addr = '0;   dq_in = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'hFF;
        exp_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, input string req);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #2;
        chk(req, {31'd0, dq_oe}, 32'd1);
        chk(req, {24'd0, dq_out}, {24'd0, exp_mem[a]});
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // Pulse of n low edges; with scramble the bus changes after the start edge.
    task automatic pulse(input bit erase, input logic [5:0] a, input logic [7:0] d,
                         input int n, input bit scramble);
        @(negedge clk);
        vpp_hv = 1'b1; a9_hv = erase; addr = a; dq_in = d; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (scramble) begin addr = ~a; dq_in = 8'h00; end
            if (k == 0) chk("R2 released in write mode", {31'd0, dq_oe}, 32'd0);
        end
        ce_n = 1'b1;
        @(negedge clk);
        vpp_hv = 1'b0; a9_hv = 1'b0;
        if (n >= (erase ? ERASE_CYC : PROG_CYC)) begin
            if (erase) for (int i = 0; i < 64; i++) exp_mem[i] = 8'hFF;
            else exp_mem[a] = exp_mem[a] & d;
        end else begin
            exp_err = 1'b1;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 err after reset", {31'd0, err}, 32'd0);
        chk("R1 bus idle after reset", {31'd0, dq_oe}, 32'd0);
        rd(6'd0, "R1 byte 0 erased");
        rd(6'd63, "R1 byte 63 erased");
    endtask

    task automatic t_read_release();
        @(negedge clk);
        addr = 6'd3; ce_n = 1'b0; oe_n = 1'b1; #2;
        chk("R2 oe_n high releases", {31'd0, dq_oe}, 32'd0);
        chk("R2 released bus is zero", {24'd0, dq_out}, 32'd0);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        chk("R2 ce_n high releases", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b1;
    endtask

    task automatic t_program();
        pulse(1'b0, 6'd5, 8'hA5, PROG_CYC, 1'b0);
        rd(6'd5, "R4 minimum width programs");
        pulse(1'b0, 6'd5, 8'h0F, PROG_CYC + 5, 1'b0);
        rd(6'd5, "R4 program ANDs old and new");
        pulse(1'b0, 6'd9, 8'h3C, PROG_CYC, 1'b1);
        rd(6'd9, "R3 address/data latched at start");
        rd(6'd54, "R3 scrambled address untouched");
        chk("R4 no error on full pulses", {31'd0, err}, 32'd0);
    endtask

    task automatic t_short_prog();
        pulse(1'b0, 6'd6, 8'h00, PROG_CYC - 1, 1'b0);
        rd(6'd6, "R6 short program leaves byte");
        chk("R6 short program sets err", {31'd0, err}, {31'd0, exp_err});
        pulse(1'b0, 6'd7, 8'h11, PROG_CYC, 1'b0);
        rd(6'd7, "R4 program after error");
        chk("R6 err stays set", {31'd0, err}, 32'd1);
    endtask

    task automatic t_ident();
        @(negedge clk);
        a9_hv = 1'b1; oe_n = 1'b0; ce_n = 1'b1; addr = 6'd0; #2;
        chk("R7 manufacturer code", {23'd0, dq_oe, dq_out}, {23'd0, 1'b1, 8'hBF});
        addr = 6'd1; #1;
        chk("R7 device code", {23'd0, dq_oe, dq_out}, {23'd0, 1'b1, 8'hA4});
        ce_n = 1'b0; addr = 6'h3E; #1;
        chk("R7 upper bits and ce_n ignored", {23'd0, dq_oe, dq_out}, {23'd0, 1'b1, 8'hBF});
        ce_n = 1'b1; vpp_hv = 1'b1; #1;
        chk("R2 both flags release bus", {31'd0, dq_oe}, 32'd0);
        vpp_hv = 1'b0; a9_hv = 1'b0; oe_n = 1'b1;
    endtask

    task automatic t_erase();
        pulse(1'b0, 6'd12, 8'h00, PROG_CYC, 1'b0);
        pulse(1'b1, 6'd0, 8'h00, ERASE_CYC - 1, 1'b0);
        rd(6'd12, "R6 short erase leaves array");
        chk("R6 short erase sets err", {31'd0, err}, 32'd1);
        pulse(1'b1, 6'd0, 8'h00, ERASE_CYC, 1'b0);
        rd(6'd12, "R5 erase restores FF");
        rd(6'd5, "R5 erase restores FF");
    endtask

    task automatic t_no_edge();
        pulse(1'b0, 6'd20, 8'hF0, PROG_CYC, 1'b0);
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        vpp_hv = 1'b1; addr = 6'd20; dq_in = 8'h00;
        repeat (PROG_CYC + 10) @(negedge clk);
        a9_hv = 1'b1;
        repeat (ERASE_CYC + 2) @(negedge clk);
        a9_hv = 1'b0; vpp_hv = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        rd(6'd20, "R9 held ce_n writes nothing");
        chk("R9 held ce_n no error", {31'd0, err}, 32'd0);
    endtask

    task automatic t_mode_loss();
        // Full-width program ended by dropping the voltage flag, ce_n still low.
        @(negedge clk);
        vpp_hv = 1'b1; addr = 6'd30; dq_in = 8'h81; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (PROG_CYC) @(negedge clk);
        vpp_hv = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        exp_mem[30] = 8'h81;
        rd(6'd30, "R8 flag loss ends full pulse");
        chk("R8 no error on full pulse", {31'd0, err}, 32'd0);
        // Same, cut short.
        @(negedge clk);
        vpp_hv = 1'b1; addr = 6'd31; dq_in = 8'h00;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (PROG_CYC / 2) @(negedge clk);
        vpp_hv = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        rd(6'd31, "R8 flag loss short pulse no write");
        chk("R8 flag loss short pulse err", {31'd0, err}, 32'd1);
    endtask

    task automatic t_erase_ident();
        pulse(1'b0, 6'd40, 8'h12, PROG_CYC, 1'b0);
        @(negedge clk);
        vpp_hv = 1'b1; a9_hv = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (ERASE_CYC) @(negedge clk);
        vpp_hv = 1'b0; ce_n = 1'b1; oe_n = 1'b0; addr = 6'd0; #2;
        chk("R7 ident in erase-end cycle", {23'd0, dq_oe, dq_out}, {23'd0, 1'b1, 8'hBF});
        addr = 6'd1; #1;
        chk("R7 ident device in erase-end cycle", {23'd0, dq_oe, dq_out}, {23'd0, 1'b1, 8'hA4});
        @(negedge clk);
        a9_hv = 1'b0; oe_n = 1'b1;
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'hFF;
        rd(6'd40, "R5 erase committed alongside ident");
        chk("R5 erase no error", {31'd0, err}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        exp_err = 1'b0;
        t_reset();
        t_read_release();
        t_program();
        t_short_prog();
        t_reset();
        t_ident();
        t_erase();
        t_reset();
        t_no_edge();
        t_mode_loss();
        t_reset();
        t_erase_ident();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule